// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a small 32-bit integer core. Every cycle it reads the instruction at the current PC from a small byte-organised instruction store, assembled little-endian from four consecutive byte cells. It recognises conditional branches and the jump-and-link instruction, rebuilds their scattered immediate offsets, and evaluates the branch condition on the two source operand values supplied by the register stage. The result is the address that the PC loads at the next clock edge.

Without a redirect the PC steps forward by one instruction, four bytes. A taken branch or a jump moves the PC to the current PC plus the sign-extended offset. A jump also presents the return address, PC + 4, together with a write strobe for the destination register. A stall input freezes the PC and suppresses every redirect and link write. The instruction store is filled through a simple byte write port before the program runs. The reset input is asynchronous and active-low; it is released through an internal synchronizer.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc` reads 0 until the first cycle in which the PC is allowed to advance.
- R2: With `stall` low, an instruction whose opcode field (bits 6:0) is neither 1100011 nor 1101111 gives `redirect` = 0, `link_we` = 0 and `next_pc` = `pc` + 4. The PC takes that value at the next rising clock edge.
- R3: `instr` equals the bytes stored at addresses `pc`+3, `pc`+2, `pc`+1 and `pc`, from most to least significant, with the byte address taken modulo the store size (256 bytes).
- R4: For opcode 1100011, funct3 (bits 14:12) 000 takes the branch when `rs1_val` equals `rs2_val`, and 001 takes it when they differ.
- R5: For opcode 1100011, funct3 110 takes the branch when `rs1_val` < `rs2_val` as unsigned numbers, and 111 takes it when `rs1_val` >= `rs2_val` as unsigned numbers (equal operands count as taken).
- R6: For opcode 1100011, every funct3 other than 000, 001, 110 and 111 never redirects, and `next_pc` is then `pc` + 4.
- R7: A taken branch sets `redirect` = 1 and `next_pc` = `pc` + offset. The offset is a signed 13-bit value: bit 12 from instr[31], bit 11 from instr[7], bits 10:5 from instr[30:25], bits 4:1 from instr[11:8], bit 0 zero. Backward offsets must work.
- R8: Opcode 1101111 always redirects to `pc` + offset. The offset is a signed 21-bit value: bit 20 from instr[31], bits 19:12 from instr[19:12], bit 11 from instr[20], bits 10:1 from instr[30:21], bit 0 zero.
- R9: For opcode 1101111 with `stall` low, `link_we` = 1 and `link_val` = `pc` + 4. For every other case `link_we` = 0.
- R10: While `stall` is high, `redirect` = 0, `link_we` = 0, `next_pc` = `pc`, and the PC keeps its value across the clock edge.
- R11: A byte presented on `imem_wdata` with `imem_we` high is stored at `imem_waddr` on the rising clock edge. It is visible in `instr` from the next cycle whenever that address falls inside the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stall | input | 1 | Hold the PC and suppress redirect and link write |
| rs1_val | input | 32 | First source operand of the current instruction |
| rs2_val | input | 32 | Second source operand of the current instruction |
| imem_we | input | 1 | Byte write strobe for the instruction store |
| imem_waddr | input | 8 | Byte address of the store write |
| imem_wdata | input | 8 | Byte written into the store |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word fetched at `pc` |
| next_pc | output | 32 | Address the PC loads at the next edge |
| redirect | output | 1 | Branch taken or jump in the current cycle |
| link_val | output | 32 | Return address for the jump's destination register |
| link_we | output | 1 | Write strobe for `link_val` |

## Verification
`instr`, `redirect`, `next_pc`, `link_val` and `link_we` are combinational in `pc`, the store contents, `stall` and the operands, so they are due in the same cycle as the stimulus. `pc` changes one rising edge later. A store write shows up in `instr` one edge after it is presented, and the release of `rst_n` reaches the PC register two edges later. The bench drives inputs 1 ns after each rising edge and compares every output with its reference model at the falling edge. The model advances its PC only at the following rising edge, so every comparison lands in the cycle where the result is due.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  // branch condition selectors (funct3)
  localparam logic [2:0] COND_EQ  = 3'b000;
  localparam logic [2:0] COND_NE  = 3'b001;
  localparam logic [2:0] COND_LTU = 3'b110;
  localparam logic [2:0] COND_GEU = 3'b111;

  typedef struct packed {
    logic       is_branch;
    logic       is_jal;
    logic [2:0] cond;
  } flow_dec_t;

endpackage

// File: rtl/nextpc_rst_sync.sv
module nextpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/nextpc_imem.sv
module nextpc_imem #(
  parameter int DEPTH = 256,
  parameter int WORD_BYTES = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_byte,
  input  logic [AW-1:0]           rd_addr,
  output logic [8*WORD_BYTES-1:0] rd_word
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_byte;
    end
  end

  // one read lane per byte; lane 0 is the least significant byte
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr = rd_addr + AW'(g);
    assign rd_word[8*g +: 8] = cells[lane_addr];
  end

  a_r11_byte_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> cells[$past(wr_addr)] == $past(wr_byte));

endmodule

// File: rtl/nextpc_immgen.sv
module nextpc_immgen #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     instr_hi,
  output logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] jmp_off
);

  localparam int BR_W  = 13;
  localparam int JMP_W = 21;

  logic [BR_W-1:0]  br_raw;
  logic [JMP_W-1:0] jmp_raw;

  always_comb begin
    br_raw  = {instr_hi[31], instr_hi[7], instr_hi[30:25], instr_hi[11:8], 1'b0};
    jmp_raw = {instr_hi[31], instr_hi[19:12], instr_hi[20], instr_hi[30:21], 1'b0};
    br_off  = {{(XLEN-BR_W){br_raw[BR_W-1]}}, br_raw};
    jmp_off = {{(XLEN-JMP_W){jmp_raw[JMP_W-1]}}, jmp_raw};
  end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  flow_dec_t       dec,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            cond_hit
);

  // one shared subtractor gives both equality and unsigned borrow
  logic [XLEN:0] diff;
  logic          same;
  logic          below;

  always_comb begin
    diff  = {1'b0, op_a} - {1'b0, op_b};
    same  = ~|diff[XLEN-1:0];
    below = diff[XLEN];
  end

  always_comb begin
    cond_hit = 1'b0;
    if (dec.is_branch) begin
      unique case (dec.cond)
        COND_EQ:  cond_hit = same;
        COND_NE:  cond_hit = ~same;
        COND_LTU: cond_hit = below;
        COND_GEU: cond_hit = ~below;
        default:  cond_hit = 1'b0;
      endcase
    end
  end

  a_r4_eq_cond: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec.is_branch && dec.cond == COND_EQ) |-> cond_hit == (op_a == op_b));
  a_r4_ne_cond: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec.is_branch && dec.cond == COND_NE) |-> cond_hit == (op_a != op_b));
  a_r5_ltu_cond: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec.is_branch && dec.cond == COND_LTU) |-> cond_hit == (op_a < op_b));
  a_r5_geu_cond: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec.is_branch && dec.cond == COND_GEU) |-> cond_hit == (op_a >= op_b));
  a_r6_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec.cond == 3'b010 || dec.cond == 3'b011 || dec.cond == 3'b100 || dec.cond == 3'b101)
      |-> !cond_hit);

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          IMEM_BYTES = 256,
  parameter int          PC_STEP    = 4,
  parameter int unsigned RESET_PC   = 0,
  parameter int          RST_STAGES = 2,
  localparam int         AW         = $clog2(IMEM_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            imem_we,
  input  logic [AW-1:0]   imem_waddr,
  input  logic [7:0]      imem_wdata,
  output logic [XLEN-1:0] pc,
  output logic [ILEN-1:0] instr,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);

  logic            rst_ni;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic            pc_en;
  flow_dec_t       dec;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] jmp_off;
  logic            cond_hit;
  logic            take;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] tgt_pc;

  nextpc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ni)
  );

  nextpc_imem #(.DEPTH(IMEM_BYTES), .WORD_BYTES(ILEN/8)) u_imem (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (imem_we),
    .wr_addr (imem_waddr),
    .wr_byte (imem_wdata),
    .rd_addr (pc_q[AW-1:0]),
    .rd_word (instr)
  );

  always_comb begin
    dec.is_branch = (instr[6:0] == OPC_BRANCH);
    dec.is_jal    = (instr[6:0] == OPC_JAL);
    dec.cond      = instr[14:12];
  end

  nextpc_immgen #(.XLEN(XLEN)) u_immgen (
    .instr_hi (instr[31:7]),
    .br_off   (br_off),
    .jmp_off  (jmp_off)
  );

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .dec      (dec),
    .op_a     (rs1_val),
    .op_b     (rs2_val),
    .cond_hit (cond_hit)
  );

  // next-state logic
  always_comb begin
    seq_pc = pc_q + XLEN'(PC_STEP);
    tgt_pc = pc_q + (dec.is_jal ? jmp_off : br_off);
    take   = ~stall & (cond_hit | dec.is_jal);
    pc_en  = ~stall;
    if (take) begin
      pc_d = tgt_pc;
    end else if (pc_en) begin
      pc_d = seq_pc;
    end else begin
      pc_d = pc_q;
    end
  end

  // PC register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= XLEN'(RESET_PC);
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc       = pc_q;
  assign next_pc  = pc_d;
  assign redirect = take;
  assign link_val = seq_pc;
  assign link_we  = ~stall & dec.is_jal;

  a_r1_pc_from_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> pc_q == XLEN'(RESET_PC));
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stall && !redirect) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    stall |=> pc_q == $past(pc_q));
  a_r7_target_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |-> next_pc[0] == pc_q[0]);
  a_r9_link_with_jump: assert property (@(posedge clk) disable iff (!rst_ni)
    link_we |-> redirect);

endmodule

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb;

  localparam int DEPTH = 256;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [31:0] rs1_val, rs2_val;
  logic        imem_we;
  logic [7:0]  imem_waddr;
  logic [7:0]  imem_wdata;
  logic [31:0] pc, instr, next_pc, link_val;
  logic        redirect, link_we;

  always #4 clk = ~clk;  // 125 MHz

  nextpc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .pc(pc), .instr(instr), .next_pc(next_pc), .redirect(redirect),
    .link_val(link_val), .link_we(link_we)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  mdl_mem [DEPTH];
  logic [31:0] mdl_pc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(int off, logic [2:0] f3);
    logic [12:0] i = 13'(off);
    return {i[12], i[10:5], 5'd2, 5'd1, f3, i[4:1], i[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(int off);
    logic [20:0] i = 21'(off);
    return {i[20], i[10:1], i[11], i[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic logic [31:0] mdl_word(logic [31:0] a);
    logic [31:0] w = 0;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mdl_mem[(a + k) % DEPTH];
    return w;
  endfunction

  // write a word through the byte port, stall held by caller
  task automatic put_word(int addr, logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      imem_we    = 1'b1;
      imem_waddr = 8'(addr + k);
      imem_wdata = w[8*k +: 8];
      mdl_mem[(addr + k) % DEPTH] = w[8*k +: 8];
      @(posedge clk); #1;
    end
    imem_we = 1'b0;
  endtask

  // one cycle: drive, compare at falling edge, advance model at rising edge
  task automatic step(logic st, logic [31:0] a, logic [31:0] b);
    logic [31:0] w, exp_next;
    logic [6:0]  op;
    logic [2:0]  f3;
    int          off;
    bit          take, is_b, is_j;
    string       tag;
    stall = st; rs1_val = a; rs2_val = b;
    @(negedge clk);
    w  = mdl_word(mdl_pc);
    op = w[6:0];
    f3 = w[14:12];
    is_b = (op == 7'b1100011);
    is_j = (op == 7'b1101111);
    take = 0;
    off  = 0;
    if (is_b) begin
      off = int'(w[7]) * 2048 + int'(w[30:25]) * 32 + int'(w[11:8]) * 2 - (w[31] ? 4096 : 0);
      case (f3)
        3'b000: take = (a == b);
        3'b001: take = (a != b);
        3'b110: take = (a < b);
        3'b111: take = (a >= b);
        default: take = 0;
      endcase
    end
    if (is_j) begin
      off  = int'(w[19:12]) * 4096 + int'(w[20]) * 2048 + int'(w[30:21]) * 2
             - (w[31] ? 1048576 : 0);
      take = 1;
    end
    if (st) take = 0;
    exp_next = st ? mdl_pc : (take ? mdl_pc + 32'(off) : mdl_pc + 32'd4);
    if (st) tag = "R10";
    else if (is_j) tag = "R8";
    else if (is_b && (f3 == 3'b000 || f3 == 3'b001)) tag = "R4";
    else if (is_b && (f3 == 3'b110 || f3 == 3'b111)) tag = "R5";
    else if (is_b) tag = "R6";
    else tag = "R2";
    chk("R3 instr", instr, w);
    chk({tag, " pc"}, pc, mdl_pc);
    chk({tag, " redirect"}, 32'(redirect), 32'(take));
    chk((is_b && take) ? "R7 next_pc" : {tag, " next_pc"}, next_pc, exp_next);
    chk("R9 link_we", 32'(link_we), 32'(!st && is_j));
    if (!st && is_j) chk("R9 link_val", link_val, mdl_pc + 32'd4);
    @(posedge clk); #1;
    mdl_pc = exp_next;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b1; rs1_val = 0; rs2_val = 0;
    imem_we = 1'b0; imem_waddr = 0; imem_wdata = 0;
    mdl_pc = 0;
    @(posedge clk); #1;
    for (int a = 0; a < DEPTH; a += 4) put_word(a, NOP);
    put_word(4,  enc_b(8, 3'b000));
    put_word(8,  enc_b(-8, 3'b110));
    put_word(12, enc_b(-8, 3'b001));
    put_word(16, enc_b(16, 3'b110));
    put_word(20, enc_b(-20, 3'b111));
    put_word(24, enc_b(8, 3'b010));
    put_word(28, enc_j(16));
    put_word(32, enc_b(8, 3'b111));
    put_word(36, enc_b(-36, 3'b101));
    put_word(40, enc_j(-40));
    put_word(44, enc_j(32'h1_1000 - 44));
    @(negedge clk);
    chk("R1 pc in reset", pc, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) step(1'b1, 0, 0);
    chk("R1 pc after release", pc, 32'h0);

    step(0, 0, 0);                       // 0 nop -> 4
    step(0, 7, 7);                       // beq taken -> 12
    step(0, 3, 3);                       // bne not taken -> 16
    step(0, 1, 32'hFFFF_FFFF);           // bltu unsigned taken -> 32
    step(0, 5, 7);                       // bgeu not taken -> 36
    step(0, 1, 0);                       // funct3 101 ignored -> 40
    step(1, 0, 0);                       // stalled jal
    step(0, 0, 0);                       // jal back -> 0
    step(0, 0, 0);
    step(0, 1, 2);                       // beq not taken -> 8
    step(0, 32'hFFFF_FFFF, 1);           // bltu not taken -> 12
    step(0, 1, 2);                       // bne taken -> 4
    step(0, 0, 0);                       // beq -> 12
    step(0, 4, 4);                       // bne -> 16
    step(0, 2, 2);                       // bltu equal not taken -> 20
    step(0, 9, 9);                       // bgeu equal taken -> 0
    step(0, 0, 0); step(0, 0, 1); step(0, 5, 5); step(0, 3, 3);
    step(0, 2, 1); step(0, 1, 2);        // ... -> 24
    step(0, 6, 6);                       // funct3 010 ignored -> 28
    step(0, 0, 0);                       // jal -> 44
    step(0, 0, 0);                       // long jal upward
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pick [4] = '{32'd0, 32'd1, 32'd5, 32'hFFFF_FFFF};
      logic [31:0] a = pick[$urandom_range(3)];
      logic [31:0] b = ($urandom_range(3) == 0) ? $urandom() : pick[$urandom_range(3)];
      step(($urandom_range(3) == 0), a, b);
    end

    // asynchronous reset in mid-run
    stall = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1 pc async reset", pc, 32'h0);
    mdl_pc = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) step(1'b1, 0, 0);

    // rewrite word 0 and fetch it
    put_word(0, enc_b(8, 3'b000));
    @(negedge clk);
    chk("R11 rewritten word", instr, enc_b(8, 3'b000));
    @(posedge clk); #1;
    step(0, 11, 11);                     // beq taken -> 8
    chk("R7 landed after beq", pc, 32'd8);
    step(0, 3, 2);                       // bltu not taken -> 12
    step(0, 3, 2);                       // bne taken back to 4

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule